// File: doc/BRIEF.md
# Ethernet Transmit Jabber Controller

This block guards the transmit side of a 10 Mb/s twisted-pair port against a stuck-on transmitter. It times each continuous burst of internal transmit activity. A burst that runs past a configurable limit puts the port into a jabbered state. In that state, transmit data no longer reaches the line driver. Link test pulse requests still pass through unchanged.

The port leaves the jabbered state only after the internal transmit stream has stayed idle for a whole unjab interval. Any renewed activity during that interval restarts the idle count. A sticky status bit records that a jabber event took place. Carrier sense is built from receive activity and own transmission while the port is normal. While the port is jabbered, carrier sense follows receive activity only. A configuration input turns the whole protection off.

Both times are parameters given in clock cycles. The defaults are 50 ms and 500 ms at 100 MHz. Short values are used in simulation.

Top module: `tx_jabber_ctrl`

## Requirements
- R1: After reset the port is in the normal state, both counters are zero, jab_status_o is 0, and tx_data_en_o equals tx_active_i.
- R2: The port enters the jabbered state at the clock edge that samples tx_active_i high for the JAB_CYCLES-th consecutive time, provided jab_disable_i is 0.
- R3: Any cycle with tx_active_i low restarts the burst count, so separate bursts never add up.
- R4: While the port is jabbered and jab_disable_i is 0, tx_data_en_o is 0 whatever tx_active_i is.
- R5: lp_en_o equals lp_req_i in every cycle and in every state.
- R6: The edge that enters the jabbered state sets jab_status_o to 1. It stays 1 until it is cleared as R7 allows.
- R7: stat_rd_i clears jab_status_o at the next edge only when the port was not jabbered in that cycle. A read in the same cycle as a jabber entry leaves the bit at 1.
- R8: A jabbered port returns to normal at the edge that samples tx_active_i low for the UNJAB_CYCLES-th consecutive time.
- R9: A cycle with tx_active_i high while the port is jabbered restarts the unjab idle count at zero.
- R10: crs_o equals rx_active_i | tx_active_i in the normal state, and equals rx_active_i in the jabbered state.
- R11: With jab_disable_i at 1, tx_data_en_o equals tx_active_i. A jabbered port returns to normal at the next edge, and no jabber entry takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_active_i | input | 1 | Internal transmit stream active |
| rx_active_i | input | 1 | Valid receive activity on the line |
| jab_disable_i | input | 1 | 1 turns jabber protection off |
| stat_rd_i | input | 1 | Status read strobe, one cycle |
| lp_req_i | input | 1 | Link test pulse request |
| tx_data_en_o | output | 1 | Gated transmit data enable to driver |
| lp_en_o | output | 1 | Link pulse enable to driver |
| jab_status_o | output | 1 | Sticky jabber-detected status |
| crs_o | output | 1 | Carrier sense |

## Verification
The status register can receive a set and a clear in the same cycle. The bench pulses stat_rd_i on the very cycle whose edge enters the jabbered state. It also pulses stat_rd_i on the last idle cycle before unjab. In both cases the bit must stay at 1, and a later read in the normal state must clear it. The unjab count and the restart from transmit activity also meet, when a single active cycle lands just before the interval would expire. The behavioural reference model predicts every output on every clock, so a wrong order in any of these cases shows up as a mismatch.

// File: rtl/tx_jabber_pkg.sv
package tx_jabber_pkg;
  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_JAB  = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jab_run_timer.sv
// Counts consecutive cycles with run_i high; hit_o flags the LIMIT-th.
module jab_run_timer #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam logic [CW-1:0] LastCnt = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || hit_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LIMIT);
  p_gap_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/jab_status_reg.sv
module jab_status_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic hold_i,
  output logic stat_o
);
  logic stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              stat_q <= 1'b0;
    else if (set_i)           stat_q <= 1'b1;
    else if (rd_i && !hold_i) stat_q <= 1'b0;
  end

  assign stat_o = stat_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_o);
  p_no_clear_while_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && stat_o) |=> stat_o);
endmodule

// File: rtl/tx_jabber_ctrl.sv
module tx_jabber_ctrl
  import tx_jabber_pkg::*;
#(
  parameter int JAB_CYCLES   = 5_000_000,
  parameter int UNJAB_CYCLES = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  input  logic rx_active_i,
  input  logic jab_disable_i,
  input  logic stat_rd_i,
  input  logic lp_req_i,
  output logic tx_data_en_o,
  output logic lp_en_o,
  output logic jab_status_o,
  output logic crs_o
);
  jab_state_e state_q, state_d;
  logic jabbed, jab_run, jab_hit, idle_run, unjab_hit;

  assign jabbed   = (state_q == ST_JAB);
  assign jab_run  = tx_active_i && !jabbed && !jab_disable_i;
  assign idle_run = jabbed && !tx_active_i && !jab_disable_i;

  jab_run_timer #(.LIMIT(JAB_CYCLES)) u_burst_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (jab_run),
    .hit_o (jab_hit)
  );

  jab_run_timer #(.LIMIT(UNJAB_CYCLES)) u_unjab_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (idle_run),
    .hit_o (unjab_hit)
  );

  always_comb begin
    state_d = state_q;
    if (jab_disable_i)                   state_d = ST_OPEN;
    else if (!jabbed && jab_hit)         state_d = ST_JAB;
    else if (jabbed && unjab_hit)        state_d = ST_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OPEN;
    else         state_q <= state_d;
  end

  jab_status_reg u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (jab_hit),
    .rd_i  (stat_rd_i),
    .hold_i(jabbed),
    .stat_o(jab_status_o)
  );

  // Data gated in jabber state; link pulses never gated.
  assign tx_data_en_o = tx_active_i && (!jabbed || jab_disable_i);
  assign lp_en_o      = lp_req_i;
  assign crs_o        = jabbed ? rx_active_i : (rx_active_i || tx_active_i);

  p_entry_sets_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jabbed) |-> jab_status_o);
  p_entry_needs_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jabbed) |-> $past(tx_active_i));
  p_exit_after_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(jabbed) && !$past(jab_disable_i)) |-> !$past(tx_active_i));
  p_disable_forces_open_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jab_disable_i |=> !jabbed);
  p_block_when_jabbed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jabbed && !jab_disable_i) |-> !tx_data_en_o);
endmodule

// File: tb/tx_jabber_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_jabber_ctrl_tb_top;
  localparam int JAB   = 20;
  localparam int UNJAB = 30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_active_i = 0, rx_active_i = 0, jab_disable_i = 0, stat_rd_i = 0, lp_req_i = 0;
  logic tx_data_en_o, lp_en_o, jab_status_o, crs_o;

  int n_checks = 0;
  int n_fail = 0;

  // reference model state
  bit m_jab = 0, m_stat = 0;
  int m_run = 0, m_idle = 0;

  always #5 clk_i = ~clk_i;

  tx_jabber_ctrl #(.JAB_CYCLES(JAB), .UNJAB_CYCLES(UNJAB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_active_i(tx_active_i), .rx_active_i(rx_active_i),
    .jab_disable_i(jab_disable_i), .stat_rd_i(stat_rd_i), .lp_req_i(lp_req_i),
    .tx_data_en_o(tx_data_en_o), .lp_en_o(lp_en_o), .jab_status_o(jab_status_o), .crs_o(crs_o)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    bit was_jab, entered;
    was_jab = m_jab;
    entered = 0;
    if (!rst_ni) begin
      m_jab = 0; m_stat = 0; m_run = 0; m_idle = 0;
    end else begin
      if (jab_disable_i) begin
        m_jab = 0; m_run = 0; m_idle = 0;
      end else if (!m_jab) begin
        if (tx_active_i) begin
          m_run++;
          if (m_run == JAB) begin m_jab = 1; m_run = 0; m_idle = 0; entered = 1; end
        end else m_run = 0;
      end else begin
        if (tx_active_i) m_idle = 0;
        else begin
          m_idle++;
          if (m_idle == UNJAB) begin m_jab = 0; m_idle = 0; end
        end
      end
      if (entered) m_stat = 1;
      else if (stat_rd_i && !was_jab) m_stat = 0;
    end
  end

  always @(negedge clk_i) begin
    string t;
    if (!rst_ni) t = "R1";
    else if (jab_disable_i) t = "R11";
    else if (m_jab) t = "R4";
    else t = "R2";
    check(tx_data_en_o, tx_active_i & (!m_jab | jab_disable_i), t);
    check(lp_en_o, lp_req_i, "R5");
    check(crs_o, m_jab ? rx_active_i : (rx_active_i | tx_active_i), "R10");
    check(jab_status_o, m_stat, m_stat ? "R6" : "R7");
  end

  task automatic step(input bit tx, input bit rx, input bit rd, input bit lp, input bit dis);
    tx_active_i = tx; rx_active_i = rx; stat_rd_i = rd; lp_req_i = lp; jab_disable_i = dis;
    @(posedge clk_i); #1;
  endtask

  task automatic run(input int n, input bit tx);
    for (int i = 0; i < n; i++) step(tx, i[1], 1'b0, i[2], 1'b0);
  endtask

  task automatic probe(input bit exp, input string tag);
    tx_active_i = 1; stat_rd_i = 0; jab_disable_i = 0;
    @(negedge clk_i);
    check(tx_data_en_o, exp, tag);
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check(jab_status_o, 1'b0, "R1");
    check(tx_data_en_o, 1'b0, "R1");
    rst_ni = 1;
    // R3: two short bursts with a gap never jab
    run(JAB - 1, 1'b1);
    run(1, 1'b0);
    run(JAB - 2, 1'b1);
    probe(1'b1, "R3");
    run(1, 1'b0);
    probe(1'b1, "R3");
    run(3, 1'b0);
    // R2: long burst jabs; read during jabber keeps status
    run(JAB + 5, 1'b1);
    step(1, 1, 1, 1, 0);
    check(jab_status_o, 1'b1, "R7");
    run(10, 1'b1);
    // R9: retransmit in unjab restarts idle count
    run(15, 1'b0);
    run(3, 1'b1);
    run(UNJAB - 1, 1'b0);
    probe(1'b0, "R9");
    // R8 with coincident read on last idle cycle
    run(UNJAB - 1, 1'b0);
    step(0, 0, 1, 0, 0);
    check(jab_status_o, 1'b1, "R7");
    probe(1'b1, "R8");
    step(0, 0, 1, 0, 0);
    check(jab_status_o, 1'b0, "R7");
    // R7: read coincident with jabber entry
    run(JAB - 1, 1'b1);
    step(1, 0, 1, 0, 0);
    check(jab_status_o, 1'b1, "R6");
    // R11: disable releases jabber and prevents entry
    step(1, 0, 0, 0, 1);
    run(1, 1'b0);
    for (int i = 0; i < 3 * JAB; i++) step(1, i[0], 0, 0, 1);
    probe(1'b1, "R11");
    run(UNJAB + 2, 1'b0);
    // mixed random traffic
    for (int s = 0; s < 300; s++) begin
      int len = $urandom_range(1, 45);
      bit tx = ($urandom_range(0, 2) != 0);
      bit dis = ($urandom_range(0, 19) == 0);
      for (int i = 0; i < len; i++)
        step(tx, $urandom_range(0, 1), ($urandom_range(0, 7) == 0), $urandom_range(0, 1), dis);
    end
    run(5, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule